// File: doc/BRIEF.md
# Single-Precision Floating-Point Comparator

This block compares two binary floating-point words and reports a single relation: less-than, equal, greater-than, or unordered. It does not decode the operands into real numbers. It treats each raw bit pattern as an unsigned integer, which works because the biased exponent sits above the fraction. Three corrections are added on top of that integer compare:

- a reversal when both operands are negative;
- a forced equality for the two signed zeros;
- an override to unordered whenever a NaN is present.

The result is registered. One operand pair can be issued every clock, and each result comes out exactly one cycle after its pair.

A mode input chooses between quiet and signaling comparison. In quiet mode, only a signaling NaN raises the invalid condition. In signaling mode, any NaN raises it. The invalid condition accumulates in a sticky flag, which stays set until a clear input drops it. The widths of the exponent and fraction are parameters, and the defaults give the 32-bit single format.

Top module: `fpcmp_top`

## Requirements
- R1: `res_valid` is high in the cycle after each cycle in which `cmp_valid` was high, and low after each cycle in which it was low. A new pair may be issued every cycle.
- R2: While `res_valid` is high, exactly one of `res_lt`, `res_eq`, `res_gt`, `res_unord` is high. While it is low, all four are low.
- R3: When both operands are non-negative and neither is a NaN, the operand whose raw bits form the larger unsigned integer is the greater one. This means infinity (exponent all ones, fraction zero) ranks above every finite value.
- R4: When both operands are negative and neither is a NaN, the operand with the larger unsigned raw value is the smaller one.
- R5: When the sign bits differ, neither operand is a NaN and the two are not both zeros, the negative operand is the smaller one.
- R6: A positive zero and a negative zero compare equal. A zero is an operand with exponent and fraction all zeros.
- R7: If either operand has an all-ones exponent and a non-zero fraction, the result is unordered and never equal. This holds even when an operand is compared with itself.
- R8: A NaN whose fraction MSB is 0 is signaling, and it sets the invalid flag in either mode. In quiet mode (`sig_mode` = 0), a NaN whose fraction MSB is 1 leaves the flag unchanged.
- R9: In signaling mode (`sig_mode` = 1), a quiet NaN operand also sets the invalid flag.
- R10: The invalid flag rises one cycle after the offending pair. It then stays high until a clear.
- R11: `flag_clr` high forces the flag to 0 on the next cycle, even if a set happens in the same cycle.
- R12: After reset, `res_valid`, all four relation outputs and `invalid_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_valid | input | 1 | Operand pair present this cycle |
| opnd_a | input | 1+EXP_W+MAN_W | Left operand, raw bits |
| opnd_b | input | 1+EXP_W+MAN_W | Right operand, raw bits |
| sig_mode | input | 1 | 1 selects signaling comparison, 0 selects quiet |
| flag_clr | input | 1 | Clears the sticky invalid flag |
| res_valid | output | 1 | Result present this cycle |
| res_lt | output | 1 | A is less than B |
| res_eq | output | 1 | A equals B |
| res_gt | output | 1 | A is greater than B |
| res_unord | output | 1 | At least one operand is a NaN |
| invalid_flag | output | 1 | Sticky invalid-operation flag |

## Verification
The bench builds the comparator with a 3-bit exponent and a 2-bit fraction. Each operand is then 6 bits wide, so all 4096 ordered pairs are swept back to back in quiet mode and again in signaling mode.

This small format still contains every class of operand: both zeros, subnormals, normals, both infinities, signaling NaNs (fraction 01) and quiet NaNs (fraction 10 and 11). Every sign combination and every self-comparison therefore meets every class.

Clear pulses are spread through the sweep. Some of them land in the same cycle as a flag set, which exercises the clear priority without a separate test.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  // Relation reported for one operand pair
  typedef enum logic [1:0] {
    REL_LT = 2'd0,
    REL_EQ = 2'd1,
    REL_GT = 2'd2,
    REL_UN = 2'd3
  } rel_t;

  // Classification of one operand
  typedef struct packed {
    logic neg;
    logic zero;
    logic inf;
    logic nan;
    logic snan;
    logic qnan;
  } opclass_t;

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] word,
  output fpcmp_pkg::opclass_t  cls
);
  localparam int W = 1 + EXP_W + MAN_W;

  function automatic fpcmp_pkg::opclass_t classify(input logic [W-1:0] w);
    fpcmp_pkg::opclass_t c;
    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] fr;
    ex     = w[W-2 -: EXP_W];
    fr     = w[MAN_W-1:0];
    c.neg  = w[W-1];
    c.zero = (ex == '0) && (fr == '0);
    c.inf  = (ex == '1) && (fr == '0);
    c.nan  = (ex == '1) && (fr != '0);
    c.qnan = c.nan && fr[MAN_W-1];
    c.snan = c.nan && !fr[MAN_W-1];
    return c;
  endfunction

  assign cls = classify(word);

endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] a,
  input  logic [EXP_W+MAN_W:0] b,
  input  fpcmp_pkg::opclass_t  ca,
  input  fpcmp_pkg::opclass_t  cb,
  output fpcmp_pkg::rel_t      rel
);
  import fpcmp_pkg::*;
  localparam int W = 1 + EXP_W + MAN_W;

  // Unsigned compare of the magnitude bits, then sign and special corrections
  function automatic rel_t relate(input logic [W-1:0] x, input logic [W-1:0] y,
                                  input opclass_t cx, input opclass_t cy);
    logic [W-2:0] mx, my;
    mx = x[W-2:0];
    my = y[W-2:0];
    if (cx.nan || cy.nan)         return REL_UN;
    if (cx.zero && cy.zero)       return REL_EQ;
    if (cx.neg != cy.neg)         return cx.neg ? REL_LT : REL_GT;
    if (mx == my)                 return REL_EQ;
    if (!cx.neg)                  return (mx > my) ? REL_GT : REL_LT;
    return (mx > my) ? REL_LT : REL_GT;
  endfunction

  assign rel = relate(a, b, ca, cb);

endmodule

// File: rtl/fpcmp_flag.sv
module fpcmp_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (clr) flag <= 1'b0;
    else if (set) flag <= 1'b1;
  end
endmodule

// File: rtl/fpcmp_top.sv
module fpcmp_top #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmp_valid,
  input  logic [EXP_W+MAN_W:0] opnd_a,
  input  logic [EXP_W+MAN_W:0] opnd_b,
  input  logic                 sig_mode,
  input  logic                 flag_clr,
  output logic                 res_valid,
  output logic                 res_lt,
  output logic                 res_eq,
  output logic                 res_gt,
  output logic                 res_unord,
  output logic                 invalid_flag
);
  import fpcmp_pkg::*;
  localparam int W = 1 + EXP_W + MAN_W;

  logic [W-1:0] opnd [2];
  opclass_t     cls  [2];
  rel_t         rel_next;
  logic         flag_set;

  assign opnd[0] = opnd_a;
  assign opnd[1] = opnd_b;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fpcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .word (opnd[i]),
      .cls  (cls[i])
    );
  end

  fpcmp_order #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_order (
    .a   (opnd_a),
    .b   (opnd_b),
    .ca  (cls[0]),
    .cb  (cls[1]),
    .rel (rel_next)
  );

  // Invalid event: signaling NaN always, quiet NaN only in signaling mode
  assign flag_set = cmp_valid &&
                    (cls[0].snan || cls[1].snan ||
                     (sig_mode && (cls[0].qnan || cls[1].qnan)));

  fpcmp_flag u_flag (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (flag_set),
    .clr  (flag_clr),
    .flag (invalid_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_lt    <= 1'b0;
      res_eq    <= 1'b0;
      res_gt    <= 1'b0;
      res_unord <= 1'b0;
    end else begin
      res_valid <= cmp_valid;
      res_lt    <= cmp_valid && (rel_next == REL_LT);
      res_eq    <= cmp_valid && (rel_next == REL_EQ);
      res_gt    <= cmp_valid && (rel_next == REL_GT);
      res_unord <= cmp_valid && (rel_next == REL_UN);
    end
  end

endmodule

// File: rtl/fpcmp_chk.sv
module fpcmp_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmp_valid,
  input logic [EXP_W+MAN_W:0] opnd_a,
  input logic [EXP_W+MAN_W:0] opnd_b,
  input logic                 flag_clr,
  input logic                 flag_set,
  input logic                 res_valid,
  input logic                 res_lt,
  input logic                 res_eq,
  input logic                 res_gt,
  input logic                 res_unord,
  input logic                 invalid_flag
);
  localparam int W = 1 + EXP_W + MAN_W;

  logic a_nan, b_nan, both_zero;
  assign a_nan     = (opnd_a[W-2 -: EXP_W] == '1) && (opnd_a[MAN_W-1:0] != '0);
  assign b_nan     = (opnd_b[W-2 -: EXP_W] == '1) && (opnd_b[MAN_W-1:0] != '0);
  assign both_zero = (opnd_a[W-2:0] == '0) && (opnd_b[W-2:0] == '0);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> res_valid);                                           // R1
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid |=> !res_valid);                                         // R1
  AST_ONE_RELATION: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $countones({res_lt, res_eq, res_gt, res_unord}) == 1); // R2
  AST_QUIET_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !(res_lt || res_eq || res_gt || res_unord));         // R2
  AST_ZEROS_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && both_zero) |=> res_eq);                               // R6
  AST_NAN_UNORDERED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && (a_nan || b_nan)) |=> (res_unord && !res_eq));        // R7
  AST_FLAG_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_set && !flag_clr) |=> invalid_flag);                          // R10
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (invalid_flag && !flag_clr) |=> invalid_flag);                      // R10
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> !invalid_flag);                                        // R11

endmodule

bind fpcmp_top fpcmp_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmp_valid    (cmp_valid),
  .opnd_a       (opnd_a),
  .opnd_b       (opnd_b),
  .flag_clr     (flag_clr),
  .flag_set     (flag_set),
  .res_valid    (res_valid),
  .res_lt       (res_lt),
  .res_eq       (res_eq),
  .res_gt       (res_gt),
  .res_unord    (res_unord),
  .invalid_flag (invalid_flag)
);

// File: tb/tb_fpcmp_top.sv
module tb_fpcmp_top;
  localparam int EW   = 3;
  localparam int MW   = 2;
  localparam int W    = 1 + EW + MW;
  localparam int BIAS = (1 << (EW - 1)) - 1;
  localparam int NW   = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_valid = 1'b0;
  logic [W-1:0] opnd_a = '0, opnd_b = '0;
  logic sig_mode = 1'b0, flag_clr = 1'b0;
  logic res_valid, res_lt, res_eq, res_gt, res_unord, invalid_flag;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fpcmp_top #(.EXP_W(EW), .MAN_W(MW)) dut (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .sig_mode(sig_mode), .flag_clr(flag_clr),
    .res_valid(res_valid), .res_lt(res_lt), .res_eq(res_eq), .res_gt(res_gt),
    .res_unord(res_unord), .invalid_flag(invalid_flag)
  );

  function automatic bit is_nan(input int w);
    return (((w >> MW) & ((1 << EW) - 1)) == (1 << EW) - 1) && ((w & ((1 << MW) - 1)) != 0);
  endfunction

  function automatic bit is_qnan(input int w);
    return is_nan(w) && (((w >> (MW - 1)) & 1) == 1);
  endfunction

  // Numeric value of a non-NaN word; infinity mapped to a huge magnitude
  function automatic real value(input int w);
    int e, m;
    real mag;
    e = (w >> MW) & ((1 << EW) - 1);
    m = w & ((1 << MW) - 1);
    if (e == (1 << EW) - 1) mag = 1.0e30;
    else if (e == 0)        mag = real'(m) * (2.0 ** (1 - BIAS - MW));
    else                    mag = real'((1 << MW) + m) * (2.0 ** (e - BIAS - MW));
    return ((w >> (W - 1)) & 1) ? -mag : mag;
  endfunction

  // Expected relation as {lt,eq,gt,un}
  function automatic logic [3:0] expect_rel(input int a, input int b);
    real va, vb;
    if (is_nan(a) || is_nan(b)) return 4'b0001;
    va = value(a);
    vb = value(b);
    if (va < vb) return 4'b1000;
    if (va > vb) return 4'b0010;
    return 4'b0100;
  endfunction

  function automatic string rel_tag(input int a, input int b);
    int sa, sb;
    sa = (a >> (W - 1)) & 1;
    sb = (b >> (W - 1)) & 1;
    if (is_nan(a) || is_nan(b)) return "R7";
    if (((a & (NW / 2 - 1)) == 0) && ((b & (NW / 2 - 1)) == 0)) return "R6";
    if (sa != sb) return "R5";
    if (sa == 1) return "R4";
    return "R3";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    bit exp_flag;
    bit p_valid, p_clr, p_set;
    int pa, pb, pmode;
    exp_flag = 1'b0;
    p_valid = 1'b0;
    p_clr = 1'b0;
    p_set = 1'b0;
    pa = 0;
    pb = 0;
    pmode = 0;

    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 valid", 32'(res_valid), 32'd0);
    check("R12 relation", 32'({res_lt, res_eq, res_gt, res_unord}), 32'd0);
    check("R12 flag", 32'(invalid_flag), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1/R2: idle cycle keeps outputs low
    check("R1 idle valid", 32'(res_valid), 32'd0);
    check("R2 idle relation", 32'({res_lt, res_eq, res_gt, res_unord}), 32'd0);

    for (int mode = 0; mode < 2; mode++) begin
      for (int a = 0; a < NW; a++) begin
        for (int b = 0; b < NW; b++) begin
          // drive the new pair
          cmp_valid = 1'b1;
          opnd_a    = W'(a);
          opnd_b    = W'(b);
          sig_mode  = mode[0];
          flag_clr  = (((a * 5 + b * 3) % 11) == 0);
          // expected flag update for the pair just driven
          p_set = (is_nan(a) && (!is_qnan(a) || mode == 1)) ||
                  (is_nan(b) && (!is_qnan(b) || mode == 1));
          exp_flag = flag_clr ? 1'b0 : (exp_flag | p_set);
          p_clr = flag_clr;
          p_valid = 1'b1;
          pa = a;
          pb = b;
          pmode = mode;
          @(negedge clk);
          check("R1 valid", 32'(res_valid), 32'd1);
          check($sformatf("%s a=%0h b=%0h", rel_tag(pa, pb), pa, pb),
                32'({res_lt, res_eq, res_gt, res_unord}), 32'(expect_rel(pa, pb)));
          if (p_clr)
            check("R11 clear priority", 32'(invalid_flag), 32'(exp_flag));
          else if (pmode == 1 && p_set)
            check("R9 signaling mode flag", 32'(invalid_flag), 32'(exp_flag));
          else if (p_set || is_nan(pa) || is_nan(pb))
            check("R8 nan flag", 32'(invalid_flag), 32'(exp_flag));
          else
            check("R10 sticky flag", 32'(invalid_flag), 32'(exp_flag));
        end
      end
      // gap between modes: R1 idle
      cmp_valid = 1'b0;
      flag_clr = 1'b0;
      @(negedge clk);
      check("R1 gap valid", 32'(res_valid), 32'd0);
      check("R2 gap relation", 32'({res_lt, res_eq, res_gt, res_unord}), 32'd0);
      check("R10 gap flag", 32'(invalid_flag), 32'(exp_flag));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule